// File: doc/BRIEF.md
# Preset-Stage 16-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with no clock and no reset. Two operands pass through three stages in a fixed order:

- **Preset.** Each operand has its own preset unit, which can clear the operand to zero and can then complement it.
- **Combine.** A combining stage either adds the two preset operands or ANDs them bit by bit.
- **Post.** A final stage can invert the combined word. It also derives a zero flag and a sign flag from the word it drives out.

There is no opcode. Any useful function comes from the way the six independent control bits are set. For example, x minus y is formed as the complement of the sum of the complemented x and y. A surrounding datapath sets the controls and operands and reads the result in the same cycle.

Top module: `preset_alu`

## Requirements
- R1: When `clear_a` is 1, operand A is treated as zero; `flip_a` then complements the value left after clearing, so with both set A becomes all ones.
- R2: `clear_b` and `flip_b` act on operand B with the same order and meaning as `clear_a` and `flip_a` act on A.
- R3: With `sel_sum` = 1 the combined word is the sum of the preset operands modulo 2^16, with no overflow or carry indication (0x7FFF+1 gives 0x8000, 0xFFFF+1 gives 0x0000).
- R4: With `sel_sum` = 0 the combined word is the bitwise AND of the preset operands.
- R5: With `flip_out` = 1 the combined word is bitwise inverted before it drives `result`; with 0 it passes unchanged.
- R6: `is_zero` is 1 exactly when `result` is 0x0000.
- R7: `is_neg` is 1 exactly when bit 15 of `result` is 1.
- R8: Control vectors are written {clear_a, flip_a, clear_b, flip_b, sel_sum, flip_out}. The following vectors give the named functions:

  | Vector | Function | Vector | Function | Vector | Function |
  |---|---|---|---|---|---|
  | 000000 | x&y | 010101 | x\|y | 000010 | x+y |
  | 010011 | x-y | 000111 | y-x | 001100 | x |
  | 110000 | y | 001101 | ~x | 110001 | ~y |
  | 001111 | -x | 110011 | -y | 011111 | x+1 |
  | 110111 | y+1 | 001110 | x-1 | 110010 | y-1 |
  | 101010 | 0 | 111111 | 1 | 111010 | all ones |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | Operand A (x) |
| opb | input | 16 | Operand B (y) |
| clear_a | input | 1 | Force operand A to zero |
| flip_a | input | 1 | Complement operand A after clearing |
| clear_b | input | 1 | Force operand B to zero |
| flip_b | input | 1 | Complement operand B after clearing |
| sel_sum | input | 1 | 1: add, 0: bitwise AND |
| flip_out | input | 1 | Invert the combined word |
| result | output | 16 | Result word |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result bit 15 is set |

## Verification
Every output of this block is combinational, so `result`, `is_zero` and `is_neg` are due in the same cycle as the operands and controls, with no register on the path. The bench changes inputs just after a falling clock edge and compares one nanosecond after the following rising edge. This leaves the adder's carry chain a full settling margin, and keeps sampling clear of the edge. All eighteen documented vectors are compared over random and edge-value operands. Separate checks cover the order of the preset steps, the wrap of the sum and the flag boundaries at 0x0000, 0x7FFF, 0x8000 and 0xFFFF.

// File: rtl/preset_alu_pkg.sv
package preset_alu_pkg;
  typedef struct packed {
    logic clear;
    logic flip;
  } preset_ctl_t;
endpackage

// File: rtl/operand_preset.sv
module operand_preset
  import preset_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  preset_ctl_t  ctl,
  output logic [W-1:0] dout
);
  logic [W-1:0] cleared;

  // Clearing happens before complementing, so clear+flip yields all ones.
  always_comb begin
    cleared = ctl.clear ? '0 : din;
    dout    = ctl.flip ? ~cleared : cleared;
  end
endmodule

// File: rtl/combine_stage.sv
module combine_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_sum,
  output logic [W-1:0] res
);
  logic [W-1:0] carry;
  logic [W-1:0] sum;
  logic [W-1:0] prop;

  assign carry[0] = 1'b0;
  assign prop     = a ^ b;

  // Ripple chain; the carry out of the top bit is dropped (sum wraps).
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = prop[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (prop[i] & carry[i]);
    end
  end

  assign res = sel_sum ? sum : (a & b);
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         invert,
  output logic [W-1:0] dout,
  output logic         zero,
  output logic         neg
);
  always_comb begin
    dout = invert ? ~din : din;
    zero = ~|dout;
    neg  = dout[W-1];
  end
endmodule

// File: rtl/preset_alu.sv
module preset_alu
  import preset_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         clear_a,
  input  logic         flip_a,
  input  logic         clear_b,
  input  logic         flip_b,
  input  logic         sel_sum,
  input  logic         flip_out,
  output logic [W-1:0] result,
  output logic         is_zero,
  output logic         is_neg
);
  preset_ctl_t  ctl_a, ctl_b;
  logic [W-1:0] pa, pb, combined;

  assign ctl_a = '{clear: clear_a, flip: flip_a};
  assign ctl_b = '{clear: clear_b, flip: flip_b};

  operand_preset #(.W(W)) u_pre_a (.din(opa), .ctl(ctl_a), .dout(pa));
  operand_preset #(.W(W)) u_pre_b (.din(opb), .ctl(ctl_b), .dout(pb));

  combine_stage #(.W(W)) u_comb (
    .a(pa), .b(pb), .sel_sum(sel_sum), .res(combined)
  );

  result_stage #(.W(W)) u_post (
    .din(combined), .invert(flip_out),
    .dout(result), .zero(is_zero), .neg(is_neg)
  );
endmodule

// File: rtl/preset_alu_chk.sv
module preset_alu_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         clear_a,
  input logic         flip_a,
  input logic         clear_b,
  input logic         flip_b,
  input logic         sel_sum,
  input logic         flip_out,
  input logic [W-1:0] result,
  input logic         is_zero,
  input logic         is_neg
);
  always_comb begin
    // R1
    clear_a_and_chk: assert (!(clear_a && !flip_a && !sel_sum && !flip_out) || result == '0)
      else $error("cleared A ANDed did not give zero");
    // R2
    clear_b_and_chk: assert (!(clear_b && !flip_b && !sel_sum && !flip_out) || result == '0)
      else $error("cleared B ANDed did not give zero");
    // R2
    ones_b_pass_chk: assert (!(!clear_a && !flip_a && clear_b && flip_b && !sel_sum && !flip_out)
                             || result == opa)
      else $error("all-ones B did not pass A through");
    // R3
    zero_sum_chk: assert (!(clear_a && !flip_a && clear_b && !flip_b && sel_sum && !flip_out)
                          || result == '0)
      else $error("sum of zeros not zero");
    // R5
    invert_ones_chk: assert (!(clear_a && flip_a && clear_b && flip_b && !sel_sum && flip_out)
                             || result == '0)
      else $error("inverted all-ones not zero");
    // R6 R7
    flag_excl_chk: assert (!(is_zero && is_neg))
      else $error("zero and negative flags both set");
  end
endmodule

bind preset_alu preset_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .clear_a(clear_a), .flip_a(flip_a),
  .clear_b(clear_b), .flip_b(flip_b), .sel_sum(sel_sum), .flip_out(flip_out),
  .result(result), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/preset_alu_test.sv
`timescale 1ns/1ps
module preset_alu_test;
  logic        clk = 1'b0;
  logic [15:0] opa, opb, result;
  logic        clear_a, flip_a, clear_b, flip_b, sel_sum, flip_out;
  logic        is_zero, is_neg;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  preset_alu uut (
    .opa(opa), .opb(opb), .clear_a(clear_a), .flip_a(flip_a),
    .clear_b(clear_b), .flip_b(flip_b), .sel_sum(sel_sum), .flip_out(flip_out),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
  );

  // Drive after a falling edge; sample 1 ns after the next rising edge.
  task automatic apply(input logic [5:0] code, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    {clear_a, flip_a, clear_b, flip_b, sel_sum, flip_out} = code;
    opa = x;
    opb = y;
    @(posedge clk);
    #1;
  endtask

  task automatic cmp(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmp_flags(input string req, input logic [15:0] exp);
    cmp({req, " is_zero"}, {15'd0, is_zero}, {15'd0, exp == 16'h0});
    cmp({req, " is_neg"},  {15'd0, is_neg},  {15'd0, exp[15]});
  endtask

  function automatic logic [5:0] row_code(input int k);
    case (k)
      0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
      3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
      6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
      9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
     12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
     15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
    endcase
  endfunction

  function automatic logic [15:0] row_exp(input int k, input logic [15:0] x, input logic [15:0] y);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return x;         4: return y;         5: return ~x;
      6: return ~y;        7: return -x;        8: return -y;
      9: return x + 16'd1; 10: return y + 16'd1; 11: return x - 16'd1;
     12: return y - 16'd1; 13: return x + y;    14: return x - y;
     15: return y - x;     16: return x & y;    default: return x | y;
    endcase
  endfunction

  task automatic t_idle_state;
    apply(6'b000000, 16'h0000, 16'h0000);
    cmp("R4 idle result", result, 16'h0000);
    cmp_flags("R6 R7 idle", 16'h0000);
  endtask

  task automatic t_table;
    logic [15:0] x, y;
    for (int r = 0; r < 24; r++) begin
      case (r)
        0: begin x = 16'h0000; y = 16'h0000; end
        1: begin x = 16'hFFFF; y = 16'h8000; end
        2: begin x = 16'h7FFF; y = 16'h0001; end
        default: begin x = 16'($urandom); y = 16'($urandom); end
      endcase
      for (int k = 0; k < 18; k++) begin
        apply(row_code(k), x, y);
        cmp($sformatf("R8 row %b", row_code(k)), result, row_exp(k, x, y));
      end
    end
  endtask

  task automatic t_preset_order;
    apply(6'b100000, 16'hBEEF, 16'hFFFF);
    cmp("R1 clear A", result, 16'h0000);
    apply(6'b110000, 16'h1234, 16'hA5C3);
    cmp("R1 clear then flip A", result, 16'hA5C3);
    apply(6'b010000, 16'h0F0F, 16'hFFFF);
    cmp("R1 flip A", result, 16'hF0F0);
    apply(6'b001000, 16'hFFFF, 16'hBEEF);
    cmp("R2 clear B", result, 16'h0000);
    apply(6'b001100, 16'h5A3C, 16'h0000);
    cmp("R2 clear then flip B", result, 16'h5A3C);
    apply(6'b000100, 16'hFFFF, 16'h00FF);
    cmp("R2 flip B", result, 16'hFF00);
  endtask

  task automatic t_wrap;
    apply(6'b000010, 16'h7FFF, 16'h0001);
    cmp("R3 wrap to 8000", result, 16'h8000);
    cmp_flags("R7 wrap neg", 16'h8000);
    apply(6'b000010, 16'hFFFF, 16'h0001);
    cmp("R3 wrap to zero", result, 16'h0000);
    cmp_flags("R6 wrap zero", 16'h0000);
    apply(6'b000010, 16'h8000, 16'h8000);
    cmp("R3 top carry dropped", result, 16'h0000);
  endtask

  task automatic t_and_invert;
    apply(6'b000000, 16'hF0F0, 16'h3C3C);
    cmp("R4 and", result, 16'h3030);
    apply(6'b000001, 16'hF0F0, 16'h3C3C);
    cmp("R5 inverted and", result, 16'hCFCF);
    apply(6'b000011, 16'h1111, 16'h2222);
    cmp("R5 inverted sum", result, 16'hCCCC);
  endtask

  task automatic t_flags;
    logic [15:0] v;
    for (int i = 0; i < 5; i++) begin
      case (i)
        0: v = 16'h0000; 1: v = 16'h8000; 2: v = 16'hFFFF;
        3: v = 16'h7FFF; default: v = 16'h0001;
      endcase
      apply(6'b001100, v, 16'h0000);
      cmp("R6 R7 pass x", result, v);
      cmp_flags($sformatf("R6 R7 value %h", v), v);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle_state();
    t_preset_order();
    t_and_invert();
    t_wrap();
    t_flags();
    t_table();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule